// File: doc/BRIEF.md
# Serial ROM Read Sequencer

This block fetches a run of bytes from a bit-serial ROM device. The caller presents a 16-bit start address and a byte count and pulses `start`. The block then claims the device bus with an ordered two-line enable handshake, shifts out a read opcode followed by the address, and clocks in the requested bytes. Each received byte appears on a byte-wide output, qualified by a one-cycle strobe.

When the last byte is in, the block gives the bus back with the mirrored two-line release sequence. It then signals completion with a one-cycle `done` pulse. The device reads sequentially, so the bytes come back in address order.

Every bus phase (setup, clock high, clock low, each handshake step) lasts `PHASE_CYC` system clocks. This lets a slow device be served from a fast core clock.

Top module: `srom_read_master`

## Requirements
- R1: The enable handshake drives `acc_hi` high first, while `acc_lo` is still high. `acc_lo` falls exactly `PHASE_CYC` cycles after `acc_hi` rose.
- R2: The release sequence drives `acc_lo` high first, while `acc_hi` is still high. `acc_hi` falls exactly `PHASE_CYC` cycles later. The transfer then ends with one `done` cycle, in which `busy` is low, `acc_hi` is 0 and `acc_lo` is 1.
- R3: The first 24 clocked bits on `sdo` are the opcode 0x03, then the address high byte, then the address low byte, each sent MSB first.
- R4: `sdo` is set while `sclk` is low and stays stable for the whole time `sclk` is high. `sclk` is only high while `acc_hi`=1 and `acc_lo`=0.
- R5: Each input bit is sampled from `sdi` at the end of its `sclk` high phase and shifted into the byte from the LSB side, so the first bit received is bit 7. After 8 input bits, `rd_data` carries the byte and `rd_valid` is high for one cycle.
- R6: A request for N bytes produces exactly N `rd_valid` strobes and 24+8·N `sclk` pulses. The bytes are the device's contents at consecutive addresses from the start address; the device's address counter wraps at 0xFFFF.
- R7: A count of zero still performs the enable, the 24-bit opcode/address phase and the release, but raises no `rd_valid`.
- R8: A `start` pulse while `busy` is high is ignored. The running transfer keeps its latched address and count, and no second transfer follows.
- R9: Every `sclk` high phase lasts exactly `PHASE_CYC` cycles.
- R10: After reset, `busy`, `done`, `rd_valid`, `sclk`, `sdo` and `acc_hi` are 0 and `acc_lo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| addr | input | 16 | Start address of the read |
| count | input | 10 | Number of bytes to read |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe qualifying rd_data |
| acc_hi | output | 1 | Access enable, high half of the pair |
| acc_lo | output | 1 | Access enable, low half of the pair |
| sclk | output | 1 | Serial bus clock |
| sdo | output | 1 | Serial data toward the device |
| sdi | input | 1 | Serial data from the device |

## Verification
A slot counter that is off by one shows up within one transfer. The bench's bus model then decodes a wrong opcode or address, or the `sclk` pulse count moves away from 24+8·N, before `done` is reached. A byte assembled in the wrong order or sampled in the wrong phase corrupts the very first `rd_valid` byte. A phase timer that drifts changes the `acc_lo` fall distance and the `sclk` high width, and this is measured on the first pulse. A handshake step taken out of order breaks the level relations checked at each `acc_hi` and `acc_lo` edge.

// File: rtl/srom_pkg.sv
package srom_pkg;

    localparam int CMD_BITS  = 8;
    localparam int BYTE_BITS = 8;
    localparam logic [CMD_BITS-1:0] READ_OPCODE = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EN_HI,
        ST_EN_LO,
        ST_SEND,
        ST_RECV,
        ST_REL_LO,
        ST_REL_HI
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_HIGH,
        PH_LOW
    } bit_phase_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } access_pair_t;

    localparam access_pair_t ACCESS_RELEASED = '{hi: 1'b0, lo: 1'b1};

endpackage

// File: rtl/srom_phase_timer.sv
module srom_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(PHASE_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign tick = !hold && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (PHASE_CYC > 1) begin : g_spacing
            assert_tick_gap_R9: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/srom_bit_engine.sv
module srom_bit_engine
    import srom_pkg::*;
#(
    parameter int HDR_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 load,
    input  logic [HDR_BITS-1:0]  hdr,
    input  logic                 active,
    input  logic                 rx_mode,
    input  logic                 sdi,
    output logic                 sclk,
    output logic                 sdo,
    output logic                 slot_end,
    output logic [BYTE_BITS-1:0] rx_byte
);
    bit_phase_e            phase_q;
    logic [HDR_BITS-1:0]   tx_sh_q;
    logic [BYTE_BITS-1:0]  rx_sh_q;
    logic                  sclk_q;
    logic                  sdo_q;

    assign sclk     = sclk_q;
    assign sdo      = sdo_q;
    assign rx_byte  = rx_sh_q;
    assign slot_end = active && tick && (phase_q == PH_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SETUP;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sclk_q  <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (load) begin
            tx_sh_q <= hdr;
            sdo_q   <= hdr[HDR_BITS-1];
            phase_q <= PH_SETUP;
            sclk_q  <= 1'b0;
        end else if (!active) begin
            phase_q <= PH_SETUP;
            sclk_q  <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (tick) begin
            case (phase_q)
                PH_SETUP: begin
                    sclk_q  <= 1'b1;
                    phase_q <= PH_HIGH;
                end
                PH_HIGH: begin
                    sclk_q  <= 1'b0;
                    phase_q <= PH_LOW;
                    if (rx_mode) begin
                        rx_sh_q <= {rx_sh_q[BYTE_BITS-2:0], sdi};
                    end
                end
                default: begin
                    phase_q <= PH_SETUP;
                    if (!rx_mode) begin
                        tx_sh_q <= {tx_sh_q[HDR_BITS-2:0], 1'b0};
                        sdo_q   <= tx_sh_q[HDR_BITS-2];
                    end
                end
            endcase
        end
    end

    assert_sdo_held_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_q |-> $stable(sdo_q));

    assert_clock_rises_from_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_q) |-> (phase_q == PH_HIGH));

endmodule

// File: rtl/srom_read_master.sv
module srom_read_master
    import srom_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 10,
    parameter int PHASE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CNT_W-1:0]     count,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 acc_hi,
    output logic                 acc_lo,
    output logic                 sclk,
    output logic                 sdo,
    input  logic                 sdi
);
    localparam int HDR_BITS = CMD_BITS + ADDR_W;
    localparam int SLOT_W   = $clog2(HDR_BITS);
    localparam logic [SLOT_W-1:0] HDR_LAST  = SLOT_W'(HDR_BITS - 1);
    localparam logic [SLOT_W-1:0] BYTE_LAST = SLOT_W'(BYTE_BITS - 1);

    seq_state_e             state_q;
    access_pair_t           acc_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [CNT_W-1:0]       left_q;
    logic [SLOT_W-1:0]      slot_q;
    logic                   busy_q;
    logic                   done_q;
    logic                   valid_q;
    logic [BYTE_BITS-1:0]   data_q;

    logic                   tick;
    logic                   slot_end;
    logic [BYTE_BITS-1:0]   rx_byte;
    logic                   eng_load;
    logic                   eng_active;
    logic                   eng_rx;
    logic                   timer_hold;

    assign timer_hold = (state_q == ST_IDLE);
    assign eng_load   = (state_q == ST_EN_LO) && tick;
    assign eng_active = (state_q == ST_SEND) || (state_q == ST_RECV);
    assign eng_rx     = (state_q == ST_RECV);

    srom_phase_timer #(
        .PHASE_CYC(PHASE_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (timer_hold),
        .tick (tick)
    );

    srom_bit_engine #(
        .HDR_BITS(HDR_BITS)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (eng_load),
        .hdr      ({READ_OPCODE, addr_q}),
        .active   (eng_active),
        .rx_mode  (eng_rx),
        .sdi      (sdi),
        .sclk     (sclk),
        .sdo      (sdo),
        .slot_end (slot_end),
        .rx_byte  (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= ACCESS_RELEASED;
            addr_q  <= '0;
            left_q  <= '0;
            slot_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q   <= addr;
                        left_q   <= count;
                        slot_q   <= '0;
                        busy_q   <= 1'b1;
                        acc_q.hi <= 1'b1;
                        state_q  <= ST_EN_HI;
                    end
                end
                ST_EN_HI: begin
                    if (tick) begin
                        acc_q.lo <= 1'b0;
                        state_q  <= ST_EN_LO;
                    end
                end
                ST_EN_LO: begin
                    if (tick) begin
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (slot_end) begin
                        if (slot_q == HDR_LAST) begin
                            slot_q <= '0;
                            if (left_q == '0) begin
                                acc_q.lo <= 1'b1;
                                state_q  <= ST_REL_LO;
                            end else begin
                                state_q <= ST_RECV;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (slot_end) begin
                        if (slot_q == BYTE_LAST) begin
                            slot_q  <= '0;
                            valid_q <= 1'b1;
                            data_q  <= rx_byte;
                            left_q  <= left_q - 1'b1;
                            if (left_q == CNT_W'(1)) begin
                                acc_q.lo <= 1'b1;
                                state_q  <= ST_REL_LO;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_REL_LO: begin
                    if (tick) begin
                        acc_q.hi <= 1'b0;
                        state_q  <= ST_REL_HI;
                    end
                end
                default: begin
                    if (tick) begin
                        done_q  <= 1'b1;
                        busy_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign rd_data  = data_q;
    assign rd_valid = valid_q;
    assign acc_hi   = acc_q.hi;
    assign acc_lo   = acc_q.lo;

    assert_enable_hi_first_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_hi) |-> acc_lo);

    assert_enable_lo_second_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(acc_lo) |-> acc_hi);

    assert_release_lo_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_lo) |-> acc_hi);

    assert_release_hi_second_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(acc_hi) |-> acc_lo);

    assert_done_released_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !acc_hi && acc_lo));

    assert_clock_gated_R4: assert property (@(posedge clk) disable iff (rst)
        sclk |-> (acc_hi && !acc_lo));

    assert_valid_in_transfer_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && state_q != ST_REL_HI) |=> busy);

endmodule

// File: tb/srom_read_master_bench.sv
module srom_read_master_bench;
    localparam int PHASE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] addr = '0;
    logic [9:0]  count = '0;
    logic        busy, done, rd_valid, acc_hi, acc_lo, sclk, sdo;
    logic [7:0]  rd_data;
    logic        sdi = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    srom_read_master #(.PHASE_CYC(PHASE)) u_srom_read_master (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .count(count),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_valid(rd_valid),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .sclk(sclk), .sdo(sdo), .sdi(sdi)
    );

    function automatic logic [7:0] rom_at(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    logic [7:0] exp_q[$];
    int         got_n = 0;
    int         rises = 0;
    int         bitn  = 0;
    logic [23:0] hdr_sh = '0;
    logic [7:0]  seen_cmd = '0;
    logic [15:0] seen_addr = '0;
    int cyc = 0, t_hi = 0, t_lo = 0, t_sr = 0;
    logic acc_hi_p = 1'b0, acc_lo_p = 1'b1, sclk_p = 1'b0, sdo_p = 1'b0;

    // Bus model and scoreboard monitor, all sampled on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rd_valid) begin
                got_n++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 extra byte", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R5 byte value", rd_data, e);
                end
            end
            if (acc_hi && !acc_hi_p) begin
                t_hi = cyc;
                check(acc_lo == 1'b1, "R1 acc_lo high at acc_hi rise", acc_lo, 1);
            end
            if (!acc_lo && acc_lo_p) begin
                check(acc_hi == 1'b1, "R1 acc_hi high at acc_lo fall", acc_hi, 1);
                check(cyc - t_hi == PHASE, "R1 enable step spacing", cyc - t_hi, PHASE);
            end
            if (acc_lo && !acc_lo_p) begin
                t_lo = cyc;
                check(acc_hi == 1'b1, "R2 acc_hi high at acc_lo rise", acc_hi, 1);
            end
            if (!acc_hi && acc_hi_p) begin
                check(acc_lo == 1'b1, "R2 acc_lo high at acc_hi fall", acc_lo, 1);
                check(cyc - t_lo == PHASE, "R2 release step spacing", cyc - t_lo, PHASE);
            end
            if (sclk && !sclk_p) begin
                t_sr = cyc;
                rises++;
                if (sdo != sdo_p) check(1'b0, "R4 sdo set before rise", sdo, sdo_p);
                if (acc_lo || !acc_hi) check(1'b0, "R4 sclk outside access", {acc_hi, acc_lo}, 2);
                if (bitn < 24) begin
                    hdr_sh = {hdr_sh[22:0], sdo};
                    if (bitn == 23) begin
                        seen_cmd  = hdr_sh[23:16];
                        seen_addr = hdr_sh[15:0];
                    end
                end else begin
                    int k;
                    logic [7:0] b;
                    k = bitn - 24;
                    b = rom_at(seen_addr + 16'(k / 8));
                    sdi <= b[7 - (k % 8)];
                end
                bitn++;
            end
            if (sclk && sclk_p && sdo != sdo_p) begin
                check(1'b0, "R4 sdo moved while clock high", sdo, sdo_p);
            end
            if (!sclk && sclk_p) begin
                check(cyc - t_sr == PHASE, "R9 clock high width", cyc - t_sr, PHASE);
            end
            if (acc_lo) bitn = 0;
        end
        acc_hi_p = acc_hi;
        acc_lo_p = acc_lo;
        sclk_p   = sclk;
        sdo_p    = sdo;
    end

    task automatic run(input logic [15:0] a, input int n, input bit poke);
        for (int i = 0; i < n; i++) exp_q.push_back(rom_at(a + 16'(i)));
        got_n = 0;
        rises = 0;
        @(negedge clk);
        addr  = a;
        count = 10'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            addr  = 16'h1234;
            count = 10'd7;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(busy == 1'b0, "R2 busy low with done", busy, 0);
        check(acc_hi == 1'b0 && acc_lo == 1'b1, "R2 bus released", {acc_hi, acc_lo}, 1);
        check(seen_cmd == 8'h03, "R3 opcode", seen_cmd, 8'h03);
        check(seen_addr == a, "R3 address", seen_addr, a);
        check(got_n == n, "R6 byte count", got_n, n);
        check(rises == 24 + 8 * n, "R6 clock pulses", rises, 24 + 8 * n);
        check(exp_q.size() == 0, "R6 bytes missing", exp_q.size(), 0);
        if (n == 0) check(got_n == 0, "R7 no data for zero count", got_n, 0);
        @(negedge clk);
        check(done == 1'b0, "R2 done one cycle", done, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            check(busy == 1'b0, "R8 no second transfer", busy, 0);
            check(got_n == n, "R8 no extra bytes", got_n, n);
        end
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset values observed before any request
        check(busy == 0 && done == 0 && rd_valid == 0, "R10 status idle", {busy, done, rd_valid}, 0);
        check(sclk == 0 && sdo == 0, "R10 bus lines low", {sclk, sdo}, 0);
        check(acc_hi == 0 && acc_lo == 1, "R10 access released", {acc_hi, acc_lo}, 1);
        run(16'h0102, 3, 1'b0);
        run(16'hFFFF, 2, 1'b0);   // R6 wrap of the device address
        run(16'h8000, 0, 1'b0);   // R7 zero count
        run(16'h00A5, 4, 1'b1);   // R8 start ignored while busy
        run(16'h5A5A, 1, 1'b0);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule